// File: doc/BRIEF.md
# Outer Response Event Classifier

This block sits on the response path from the outer cache network into a private cache controller. Each incoming response is turned into exactly one coherence event that the line state machine can act on. The response carries a kind code, the address of the line, a flag that says whether another private cache sent it, and a signed acknowledgement count. The block also receives the line's current state code. Any kind code outside the four legal ones raises an error instead of an event.

Next to the decoder is a single miss tracker. It holds the address of the outstanding miss, a dirty bit, and a signed count of acknowledgements still expected. Data and acknowledgement responses for the tracked address subtract their carried count from the pending count. Whether the result of that subtraction is zero decides between the "all acknowledgements in" events and the plain events.

The count is signed. A data response may therefore arrive first with a negative count, which raises the number still expected, and the invalidation acknowledgements that follow (one each) bring it back down to zero. The tracker has two states. TRK_IDLE moves to TRK_OPEN on an allocate. TRK_OPEN moves back to TRK_IDLE on a free. An allocate in TRK_OPEN re-opens the tracker with a zero count.

Top module: `rsp_evt_classifier`

## Requirements
- R1: After reset, evt_valid_o, evt_o, err_o, pend_o and trk_busy_o are all zero.
- R2: A response of kind 1 (exclusive data) always produces event bit 0 and leaves the pending count unchanged.
- R3: A response of kind 0 (data) with rsp_peer_i high, arriving while line_state_i equals 1 (load miss), produces event bit 1 and leaves the pending count unchanged.
- R4: Any other kind-0 response produces event bit 2 when (pending minus carried count) is zero, and event bit 3 otherwise. On a tracker hit, the pending count becomes that difference.
- R5: A response of kind 2 (ack) produces event bit 4 when (pending minus carried count) is zero, and event bit 5 otherwise. On a tracker hit, the pending count becomes that difference.
- R6: A response of kind 3 (writeback ack) produces event bit 6 and leaves the pending count unchanged.
- R7: alloc_i moves the tracker to TRK_OPEN, captures address and dirty bit, and zeroes the pending count. free_i moves it to TRK_IDLE and zeroes the count.
- R8: A response whose address does not match an open tracker is classified against a pending count of zero and does not change the stored count.
- R9: Kind codes 4 to 7 raise err_o for one cycle, produce no event and change no count.
- R10: Event and error outputs appear one clock after the response is presented. Without a response, evt_valid_o is low and evt_o is zero. A valid event is one-hot.
- R11: A negative carried count on a hitting data response raises the pending count, so acks of count one that follow produce event bit 5 until the last one, which produces event bit 4.
- R12: When alloc_i coincides with a response, the response is classified against the old count, and the allocation's zero count wins over the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | Open the tracker for a new miss |
| alloc_addr_i | input | AW (16) | Line address of the new miss |
| alloc_dirty_i | input | 1 | Dirty bit stored with the miss |
| free_i | input | 1 | Close the tracker |
| rsp_valid_i | input | 1 | Response present this cycle |
| rsp_kind_i | input | 3 | 0 data, 1 exclusive data, 2 ack, 3 writeback ack, 4-7 illegal |
| rsp_addr_i | input | AW (16) | Line address of the response |
| rsp_peer_i | input | 1 | Response was sent by a peer private cache |
| rsp_acks_i | input | ACKW (6) | Signed acknowledgement count carried |
| line_state_i | input | 3 | Current line state code, 1 = load miss |
| evt_valid_o | output | 1 | An event is presented |
| evt_o | output | 7 | One-hot event, bit positions as in R2-R6 |
| err_o | output | 1 | Illegal response kind seen |
| pend_o | output | PW (7) | Signed pending acknowledgement count |
| trk_busy_o | output | 1 | Tracker in TRK_OPEN |
| trk_addr_o | output | AW (16) | Tracked line address |
| trk_dirty_o | output | 1 | Tracked dirty bit |

## Verification
Every result is due exactly one clock after its stimulus. The event, the error flag, the new pending count and the tracker fields are all captured at the same rising edge. The bench drives inputs on the falling edge, and its behavioural model computes the expected values from the same inputs at that moment. The outputs are compared at the next falling edge, once per clock, so every register on the path has had exactly one edge to update.

// File: rtl/rsp_evt_pkg.sv
package rsp_evt_pkg;
    localparam logic [2:0] KIND_DATA   = 3'd0;
    localparam logic [2:0] KIND_XDATA  = 3'd1;
    localparam logic [2:0] KIND_ACK    = 3'd2;
    localparam logic [2:0] KIND_WBACK  = 3'd3;

    localparam logic [2:0] LS_LOAD_MISS = 3'd1;

    localparam int EV_XDATA     = 0;
    localparam int EV_PEER_DATA = 1;
    localparam int EV_DATA_ALL  = 2;
    localparam int EV_DATA      = 3;
    localparam int EV_ACK_LAST  = 4;
    localparam int EV_ACK       = 5;
    localparam int EV_WBACK     = 6;
    localparam int NUM_EV       = 7;

    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_OPEN = 1'b1
    } trk_state_e;
endpackage

// File: rtl/rsp_evt_decode.sv
module rsp_evt_decode
    import rsp_evt_pkg::*;
#(
    parameter int ACKW = 6,
    parameter int PW   = 7
) (
    input  logic                   rsp_valid,
    input  logic [2:0]             rsp_kind,
    input  logic                   rsp_peer,
    input  logic [2:0]             line_state,
    input  logic signed [ACKW-1:0] rsp_acks,
    input  logic signed [PW-1:0]   pend_eff,
    output logic [NUM_EV-1:0]      evt,
    output logic                   err,
    output logic                   upd_en,
    output logic signed [PW-1:0]   pend_next
);
    localparam int EXTW = PW - ACKW;

    logic signed [PW-1:0] acks_ext;
    logic                 diff_zero;

    always_comb begin
        acks_ext  = signed'({{EXTW{rsp_acks[ACKW-1]}}, rsp_acks});
        pend_next = pend_eff - acks_ext;
        diff_zero = (pend_next == '0);
    end

    always_comb begin
        evt    = '0;
        err    = 1'b0;
        upd_en = 1'b0;
        if (rsp_valid) begin
            unique case (rsp_kind)
                KIND_XDATA: evt[EV_XDATA] = 1'b1;
                KIND_DATA: begin
                    if (rsp_peer && (line_state == LS_LOAD_MISS)) begin
                        evt[EV_PEER_DATA] = 1'b1;
                    end else begin
                        upd_en = 1'b1;
                        if (diff_zero) evt[EV_DATA_ALL] = 1'b1;
                        else           evt[EV_DATA]     = 1'b1;
                    end
                end
                KIND_ACK: begin
                    upd_en = 1'b1;
                    if (diff_zero) evt[EV_ACK_LAST] = 1'b1;
                    else           evt[EV_ACK]      = 1'b1;
                end
                KIND_WBACK: evt[EV_WBACK] = 1'b1;
                default:    err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/rsp_miss_tracker.sv
module rsp_miss_tracker
    import rsp_evt_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc,
    input  logic [AW-1:0]        alloc_addr,
    input  logic                 alloc_dirty,
    input  logic                 free,
    input  logic [AW-1:0]        look_addr,
    input  logic                 upd_en,
    input  logic signed [PW-1:0] upd_val,
    output logic                 hit,
    output logic signed [PW-1:0] pend_eff,
    output logic                 busy,
    output logic [AW-1:0]        addr,
    output logic                 dirty,
    output logic signed [PW-1:0] pend
);
    trk_state_e           state_q, state_d;
    logic [AW-1:0]        addr_q;
    logic                 dirty_q;
    logic signed [PW-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: if (alloc) state_d = TRK_OPEN;
            TRK_OPEN: if (!alloc && free) state_d = TRK_IDLE;
            default:  state_d = TRK_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q == TRK_OPEN);
        hit      = busy && (look_addr == addr_q);
        pend_eff = hit ? pend_q : '0;
        addr     = addr_q;
        dirty    = dirty_q;
        pend     = pend_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            dirty_q <= 1'b0;
            pend_q  <= '0;
        end else if (alloc) begin
            addr_q  <= alloc_addr;
            dirty_q <= alloc_dirty;
            pend_q  <= '0;
        end else if (free) begin
            pend_q  <= '0;
        end else if (upd_en && hit) begin
            pend_q  <= upd_val;
        end
    end

    p_alloc_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (busy && pend_q == '0 && addr_q == $past(alloc_addr)));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pend_q == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc && !free && !upd_en) |=> $stable(pend_q));

    p_miss_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc && !free && upd_en && !hit) |=> $stable(pend_q));
endmodule

// File: rtl/rsp_evt_classifier.sv
module rsp_evt_classifier
    import rsp_evt_pkg::*;
#(
    parameter int AW          = 16,
    parameter int MAX_SHARERS = 16,
    localparam int ACKW       = $clog2(MAX_SHARERS + 1) + 1,
    localparam int PW         = ACKW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_i,
    input  logic [AW-1:0]          alloc_addr_i,
    input  logic                   alloc_dirty_i,
    input  logic                   free_i,
    input  logic                   rsp_valid_i,
    input  logic [2:0]             rsp_kind_i,
    input  logic [AW-1:0]          rsp_addr_i,
    input  logic                   rsp_peer_i,
    input  logic signed [ACKW-1:0] rsp_acks_i,
    input  logic [2:0]             line_state_i,
    output logic                   evt_valid_o,
    output logic [NUM_EV-1:0]      evt_o,
    output logic                   err_o,
    output logic signed [PW-1:0]   pend_o,
    output logic                   trk_busy_o,
    output logic [AW-1:0]          trk_addr_o,
    output logic                   trk_dirty_o
);
    logic                 hit;
    logic signed [PW-1:0] pend_eff;
    logic signed [PW-1:0] pend_next;
    logic [NUM_EV-1:0]    evt_d, evt_q;
    logic                 err_d, err_q;
    logic                 upd_en;

    rsp_miss_tracker #(.AW(AW), .PW(PW)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (alloc_i),
        .alloc_addr (alloc_addr_i),
        .alloc_dirty(alloc_dirty_i),
        .free       (free_i),
        .look_addr  (rsp_addr_i),
        .upd_en     (upd_en),
        .upd_val    (pend_next),
        .hit        (hit),
        .pend_eff   (pend_eff),
        .busy       (trk_busy_o),
        .addr       (trk_addr_o),
        .dirty      (trk_dirty_o),
        .pend       (pend_o)
    );

    rsp_evt_decode #(.ACKW(ACKW), .PW(PW)) u_dec (
        .rsp_valid (rsp_valid_i),
        .rsp_kind  (rsp_kind_i),
        .rsp_peer  (rsp_peer_i),
        .line_state(line_state_i),
        .rsp_acks  (rsp_acks_i),
        .pend_eff  (pend_eff),
        .evt       (evt_d),
        .err       (err_d),
        .upd_en    (upd_en),
        .pend_next (pend_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
            err_q <= 1'b0;
        end else begin
            evt_q <= evt_d;
            err_q <= err_d;
        end
    end

    always_comb begin
        evt_o       = evt_q;
        evt_valid_o = |evt_q;
        err_o       = err_q;
    end

    p_evt_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> ($countones(evt_o) == 1));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_i |=> (!evt_valid_o && !err_o));

    p_err_no_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_kind_i[2]) |=> (err_o && evt_o == '0));

    p_xdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_kind_i == KIND_XDATA) |=> evt_o[EV_XDATA]);

    p_peer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_kind_i == KIND_DATA && rsp_peer_i &&
         line_state_i == LS_LOAD_MISS) |=> evt_o[EV_PEER_DATA]);

    p_wback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_kind_i == KIND_WBACK) |=> evt_o[EV_WBACK]);

    p_alloc_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && rsp_valid_i) |=> (pend_o == '0));
endmodule

// File: tb/rsp_evt_classifier_bench.sv
module rsp_evt_classifier_bench;
    localparam int PERIOD = 10;
    localparam int AW     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_i = 1'b0;
    logic [AW-1:0]     alloc_addr_i = '0;
    logic              alloc_dirty_i = 1'b0;
    logic              free_i = 1'b0;
    logic              rsp_valid_i = 1'b0;
    logic [2:0]        rsp_kind_i = '0;
    logic [AW-1:0]     rsp_addr_i = '0;
    logic              rsp_peer_i = 1'b0;
    logic signed [5:0] rsp_acks_i = '0;
    logic [2:0]        line_state_i = '0;
    logic              evt_valid_o;
    logic [6:0]        evt_o;
    logic              err_o;
    logic signed [6:0] pend_o;
    logic              trk_busy_o;
    logic [AW-1:0]     trk_addr_o;
    logic              trk_dirty_o;

    int n_run  = 0;
    int n_fail = 0;

    int m_busy = 0, m_addr = 0, m_dirty = 0, m_pend = 0;

    always #(PERIOD/2) clk = ~clk;

    rsp_evt_classifier u_rsp_evt_classifier (
        .clk(clk), .rst_n(rst_n),
        .alloc_i(alloc_i), .alloc_addr_i(alloc_addr_i), .alloc_dirty_i(alloc_dirty_i),
        .free_i(free_i), .rsp_valid_i(rsp_valid_i), .rsp_kind_i(rsp_kind_i),
        .rsp_addr_i(rsp_addr_i), .rsp_peer_i(rsp_peer_i), .rsp_acks_i(rsp_acks_i),
        .line_state_i(line_state_i), .evt_valid_o(evt_valid_o), .evt_o(evt_o),
        .err_o(err_o), .pend_o(pend_o), .trk_busy_o(trk_busy_o),
        .trk_addr_o(trk_addr_o), .trk_dirty_o(trk_dirty_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input int al, input int aaddr, input int adirty,
                        input int fr, input int v, input int kind, input int raddr,
                        input int peer, input int acks, input int lst);
        int hit, pe, d, ev, er, upd;
        hit = (m_busy != 0) && (raddr == m_addr);
        pe  = hit ? m_pend : 0;
        d   = pe - acks;
        ev = 0; er = 0; upd = 0;
        if (v != 0) begin
            case (kind)
                0: if (lst == 1 && peer != 0) ev = 2;
                   else begin upd = 1; ev = (d == 0) ? 4 : 8; end
                1: ev = 1;
                2: begin upd = 1; ev = (d == 0) ? 16 : 32; end
                3: ev = 64;
                default: er = 1;
            endcase
        end
        if (al != 0) begin m_busy = 1; m_addr = aaddr; m_dirty = adirty; m_pend = 0; end
        else if (fr != 0) begin m_busy = 0; m_pend = 0; end
        else if (upd != 0 && hit != 0) m_pend = d;

        alloc_i = al[0]; alloc_addr_i = aaddr[AW-1:0]; alloc_dirty_i = adirty[0];
        free_i = fr[0]; rsp_valid_i = v[0]; rsp_kind_i = kind[2:0];
        rsp_addr_i = raddr[AW-1:0]; rsp_peer_i = peer[0];
        rsp_acks_i = acks[5:0]; line_state_i = lst[2:0];
        @(negedge clk);
        chk(tag, "evt", int'(evt_o), ev);
        chk(tag, "evt_valid", int'(evt_valid_o), (ev != 0) ? 1 : 0);
        chk(tag, "err", int'(err_o), er);
        chk(tag, "pend", int'(pend_o), m_pend);
        chk(tag, "busy", int'(trk_busy_o), m_busy);
        if (m_busy != 0) begin
            chk(tag, "addr", int'(trk_addr_o), m_addr);
            chk(tag, "dirty", int'(trk_dirty_o), m_dirty);
        end
    endtask

    initial begin
        #(PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "evt_valid", int'(evt_valid_o), 0);
        chk("R1", "evt", int'(evt_o), 0);
        chk("R1", "err", int'(err_o), 0);
        chk("R1", "pend", int'(pend_o), 0);
        chk("R1", "busy", int'(trk_busy_o), 0);

        //   tag    al aaddr    ad fr v kind raddr   peer acks lst
        step("R7",  1, 'h1234, 1, 0, 0, 0, 0,       0,  0,  0);
        step("R6",  0, 0,      0, 0, 1, 3, 'h1234,  0,  0,  0);
        step("R2",  0, 0,      0, 0, 1, 1, 'h1234,  0,  5,  1);
        step("R11", 0, 0,      0, 0, 1, 0, 'h1234,  0, -3,  2);
        step("R5",  0, 0,      0, 0, 1, 2, 'h1234,  0,  1,  2);
        step("R5",  0, 0,      0, 0, 1, 2, 'h1234,  0,  1,  2);
        step("R11", 0, 0,      0, 0, 1, 2, 'h1234,  0,  1,  2);
        step("R3",  0, 0,      0, 0, 1, 0, 'h1234,  1,  2,  1);
        step("R4",  0, 0,      0, 0, 1, 0, 'h1234,  0,  0,  1);
        step("R4",  0, 0,      0, 0, 1, 0, 'h1234,  1, -2,  2);
        step("R5",  0, 0,      0, 0, 1, 2, 'h1234,  0,  2,  2);
        step("R4",  0, 0,      0, 0, 1, 0, 'h1234,  0, -1,  3);
        step("R8",  0, 0,      0, 0, 1, 2, 'h0777,  0,  1,  2);
        step("R8",  0, 0,      0, 0, 1, 2, 'h0777,  0,  0,  2);
        step("R9",  0, 0,      0, 0, 1, 5, 'h1234,  0,  1,  2);
        step("R9",  0, 0,      0, 0, 1, 7, 'h1234,  0,  0,  1);
        step("R10", 0, 0,      0, 0, 0, 2, 'h1234,  0,  1,  2);
        step("R12", 1, 'h0abc, 0, 0, 1, 2, 'h1234,  0,  1,  2);
        step("R4",  0, 0,      0, 0, 1, 0, 'h0abc,  0, -4,  2);
        step("R7",  0, 0,      0, 1, 0, 0, 0,       0,  0,  0);
        step("R8",  0, 0,      0, 0, 1, 2, 'h0abc,  0,  0,  2);
        step("R8",  0, 0,      0, 0, 1, 0, 'h0abc,  0,  3,  0);
        step("R10", 0, 0,      0, 0, 0, 0, 0,       0,  0,  0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule